// File: doc/BRIEF.md
# Crystal Oscillator Startup Supervisor

This block supervises an external crystal oscillator from a small 32-bit register bus. Software turns the oscillator on by writing a pair of 12-bit magic codes to a control register: one code selects on or off, and the other confirms the frequency range. The block drives an enable pin to the analog pad. It then counts a programmable settling time on the crystal clock before it reports the oscillator as stable. Control writes that carry a code the block does not recognise leave the addressed field as it was and set a sticky error flag. Software clears that flag by writing a one to it.

A pause register puts a running oscillator to sleep and wakes it again, also through magic codes. Sleep drops the pad enable, so the crystal clock stops. Waking runs the full settling time again. A free 8-bit down counter runs on the crystal clock. Software loads it through a toggle handshake and reads it back through a Gray-coded synchroniser. It counts to zero and stays there. All control and status pins are plain levels. There is no streaming data path, so there is no valid/ready interface and no back-pressure.

Word addresses: 0 control, 1 status, 2 pause, 3 startup, 4 counter.

Top module: `xosc_supervisor`

## Requirements
- R1: After reset, every register reads back as follows, and `osc_en` is 0.

  | Register | Reset read value |
  |---|---|
  | control | 0 |
  | status | 0 |
  | startup | 0x000000C4 |
  | pause | 0x77616B65 (the wake code) |
  | counter | 0 |

- R2: A control write with the on/off field (bits 23:12) set to 0xFAB and the range field (bits 11:0) set to 0xAA0 switches the oscillator on. Status bit 12 then reads 1 and `osc_en` is 1. The on/off code 0xD1E switches it off, and both then read 0.
- R3: A control write whose on/off field is neither 0xFAB nor 0xD1E leaves the on/off field unchanged. A control write whose range field is not 0xAA0 leaves the range field unchanged. Either case sets status bit 24. A legal field in the same write is still taken.
- R4: Status bit 24 stays set until a status write with bit 24 at 1. A status write with bit 24 at 0 leaves it set.
- R5: The pause register reads back the last legal code written to it. Writing 0x636F6D61 enters sleep: `osc_en` goes to 0 while status bit 12 stays 1. Writing 0x77616B65 wakes the oscillator. Any other value leaves the pause state unchanged and sets status bit 24.
- R6: Status bit 31 rises only after the oscillator has run for DELAY×256 crystal periods, where DELAY is startup bits 13:0. The bit reads 0 before then.
- R7: With startup bit 20 set, the settling time is four times as long.
- R8: Switching off or entering sleep clears status bit 31 at once. Switching on again or waking starts a new full settling time.
- R9: Status bits 1:0 always read 0.
- R10: A counter write loads bits 7:0 into the crystal-domain counter. The counter then falls by one per crystal period, holds at zero, and reads back in bits 7:0.
- R11: A counter write that arrives while the previous load is still crossing to the crystal domain is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| xclk | input | 1 | Crystal clock from the analog oscillator |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| osc_en | output | 1 | Enable to the oscillator pad |

## Verification
The hardest case to reach from the ports is a counter write that lands while the previous load is still in flight across the clock boundary. The window lasts only a few crystal edges. The stimulus issues two counter writes on consecutive bus cycles: a large value, then a tiny one. A read-back shortly afterwards must still be near the large value. The settling-time checks bracket the expected instant with one read just before it and one just after, in both the ×1 and ×4 modes. They also repeat the bracket after a switch-off and after a sleep, to show that the count restarts from the beginning.

// File: rtl/xsup_pkg.sv
package xsup_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] EN_ON   = 12'hFAB;
  localparam logic [CODE_W-1:0] EN_OFF  = 12'hD1E;
  localparam logic [CODE_W-1:0] RANGE_OK = 12'hAA0;
  localparam logic [BUS_W-1:0]  NAP_CODE  = 32'h636F6D61;
  localparam logic [BUS_W-1:0]  WAKE_CODE = 32'h77616B65;

  localparam int BIT_STABLE = 31;
  localparam int BIT_BAD    = 24;
  localparam int BIT_ON     = 12;
  localparam int BIT_X4     = 20;
  localparam int ON_LO      = 12;
  localparam int ON_HI      = ON_LO + CODE_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    RG_CTRL  = 3'd0,
    RG_STAT  = 3'd1,
    RG_NAP   = 3'd2,
    RG_START = 3'd3,
    RG_CNT   = 3'd4
  } reg_sel_e;

  function automatic logic [7:0] gray_to_bin8(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/xsup_rst_sync.sv
module xsup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_no
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain[STAGES-1];
endmodule

// File: rtl/xsup_sync_bits.sv
module xsup_sync_bits #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] s1, s2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/xsup_regs.sv
module xsup_regs
  import xsup_pkg::*;
#(
  parameter int               DLY_W   = 14,
  parameter logic [DLY_W-1:0] DLY_RST = 14'hC4,
  parameter int               CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              stable_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              ack_in,
  output logic              run_o,
  output logic [DLY_W-1:0]  dly_o,
  output logic              x4_o,
  output logic              req_o,
  output logic [CNT_W-1:0]  cdata_o
);
  logic [CODE_W-1:0] en_f, fr_f;
  logic              bad, nap, x4, req_t;
  logic [DLY_W-1:0]  dly;
  logic [CNT_W-1:0]  cdata;
  reg_sel_e          idx;
  logic wr_ctrl, wr_stat, wr_nap, wr_start, wr_cnt;
  logic en_ok, fr_ok, nap_ok, pending, enabled;

  assign idx      = reg_sel_e'(addr);
  assign wr_ctrl  = sel && we && (idx == RG_CTRL);
  assign wr_stat  = sel && we && (idx == RG_STAT);
  assign wr_nap   = sel && we && (idx == RG_NAP);
  assign wr_start = sel && we && (idx == RG_START);
  assign wr_cnt   = sel && we && (idx == RG_CNT);

  assign en_ok   = (wdata[ON_HI:ON_LO] == EN_ON) || (wdata[ON_HI:ON_LO] == EN_OFF);
  assign fr_ok   = (wdata[CODE_W-1:0] == RANGE_OK);
  assign nap_ok  = (wdata == NAP_CODE) || (wdata == WAKE_CODE);
  assign pending = req_t ^ ack_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_f  <= '0;
      fr_f  <= '0;
      bad   <= 1'b0;
      nap   <= 1'b0;
      dly   <= DLY_RST;
      x4    <= 1'b0;
      req_t <= 1'b0;
      cdata <= '0;
    end else begin
      if (wr_ctrl) begin
        if (en_ok) en_f <= wdata[ON_HI:ON_LO];
        if (fr_ok) fr_f <= wdata[CODE_W-1:0];
      end
      if (wr_nap) begin
        if (wdata == NAP_CODE)       nap <= 1'b1;
        else if (wdata == WAKE_CODE) nap <= 1'b0;
      end
      if (wr_start) begin
        dly <= wdata[DLY_W-1:0];
        x4  <= wdata[BIT_X4];
      end
      if (wr_cnt && !pending) begin
        cdata <= wdata[CNT_W-1:0];
        req_t <= ~req_t;
      end
      if ((wr_ctrl && !(en_ok && fr_ok)) || (wr_nap && !nap_ok)) bad <= 1'b1;
      else if (wr_stat && wdata[BIT_BAD])                        bad <= 1'b0;
    end
  end

  assign enabled = (en_f == EN_ON);
  assign run_o   = enabled && !nap;
  assign dly_o   = dly;
  assign x4_o    = x4;
  assign req_o   = req_t;
  assign cdata_o = cdata;

  always_comb begin
    rdata = '0;
    case (idx)
      RG_CTRL:  rdata[ON_HI:0] = {en_f, fr_f};
      RG_STAT: begin
        rdata[BIT_STABLE] = stable_in && run_o;
        rdata[BIT_BAD]    = bad;
        rdata[BIT_ON]     = enabled;
      end
      RG_NAP:   rdata = nap ? NAP_CODE : WAKE_CODE;
      RG_START: begin
        rdata[DLY_W-1:0] = dly;
        rdata[BIT_X4]    = x4;
      end
      RG_CNT:   rdata[CNT_W-1:0] = cnt_in;
      default:  rdata = '0;
    endcase
  end

  assert_bad_on_illegal_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !en_ok) |=> (bad && $stable(en_f)));
  assert_range_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !fr_ok) |=> $stable(fr_f));
  assert_bad_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !(wr_stat && wdata[BIT_BAD])) |=> bad);
  assert_nap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_nap && !nap_ok) |=> (bad && $stable(nap)));
  assert_load_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> $stable(cdata));
endmodule

// File: rtl/xsup_startup.sv
module xsup_startup #(
  parameter int DLY_W     = 14,
  parameter int UNIT_LOG2 = 8
) (
  input  logic             xclk,
  input  logic             arst_n,
  input  logic [DLY_W-1:0] dly,
  input  logic             x4,
  output logic             stable_o
);
  localparam int TW = DLY_W + UNIT_LOG2 + 2;

  logic [TW-1:0] base, target, elapsed;
  logic          stable_q;

  assign base   = TW'({dly, {UNIT_LOG2{1'b0}}});
  assign target = x4 ? (base << 2) : base;

  always_ff @(posedge xclk or negedge arst_n) begin
    if (!arst_n) begin
      elapsed  <= '0;
      stable_q <= 1'b0;
    end else if (!stable_q) begin
      elapsed <= elapsed + 1'b1;
      if (elapsed + 1'b1 >= target) stable_q <= 1'b1;
    end
  end

  assign stable_o = stable_q;

  assert_stable_sticky_R6: assert property (@(posedge xclk) disable iff (!arst_n)
    stable_q |=> stable_q);
  assert_stable_after_delay_R6: assert property (@(posedge xclk) disable iff (!arst_n)
    $rose(stable_q) |-> (elapsed >= target));
endmodule

// File: rtl/xsup_xcount.sv
module xsup_xcount #(
  parameter int CNT_W = 8
) (
  input  logic             xclk,
  input  logic             arst_n,
  input  logic             req_t,
  input  logic [CNT_W-1:0] data,
  output logic             ack_o,
  output logic [CNT_W-1:0] gray_o
);
  logic [2:0]       rq;
  logic             load;
  logic [CNT_W-1:0] cnt, gray_q;

  assign load = rq[2] ^ rq[1];

  always_ff @(posedge xclk or negedge arst_n) begin
    if (!arst_n) begin
      rq     <= '0;
      cnt    <= '0;
      gray_q <= '0;
    end else begin
      rq     <= {rq[1:0], req_t};
      gray_q <= cnt ^ (cnt >> 1);
      if (load)            cnt <= data;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign ack_o  = rq[2];
  assign gray_o = gray_q;

  assert_count_floor_R10: assert property (@(posedge xclk) disable iff (!arst_n)
    (cnt == '0 && !load) |=> (cnt == '0));
  assert_count_step_R10: assert property (@(posedge xclk) disable iff (!arst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/xosc_supervisor.sv
module xosc_supervisor
  import xsup_pkg::*;
#(
  parameter int               DLY_W     = 14,
  parameter logic [DLY_W-1:0] DLY_RST   = 14'hC4,
  parameter int               UNIT_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xclk,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              osc_en
);
  localparam int CNT_W = 8;

  logic             run, x4, req_t, ack_x, ack_s, stable_x, stable_s;
  logic             t_rst_n, x_rst_n, s_rst_n;
  logic [DLY_W-1:0] dly;
  logic [CNT_W-1:0] cdata, gray_x, gray_s, cnt_s;

  assign s_rst_n = rst_n && run;

  xsup_regs #(.DLY_W(DLY_W), .DLY_RST(DLY_RST), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .stable_in(stable_s), .cnt_in(cnt_s),
    .ack_in(ack_s), .run_o(run), .dly_o(dly), .x4_o(x4), .req_o(req_t),
    .cdata_o(cdata)
  );

  xsup_rst_sync #(.STAGES(2)) u_trst (.clk(xclk), .arst_n(s_rst_n), .rst_no(t_rst_n));
  xsup_rst_sync #(.STAGES(2)) u_xrst (.clk(xclk), .arst_n(rst_n),   .rst_no(x_rst_n));

  xsup_startup #(.DLY_W(DLY_W), .UNIT_LOG2(UNIT_LOG2)) u_start (
    .xclk(xclk), .arst_n(t_rst_n), .dly(dly), .x4(x4), .stable_o(stable_x)
  );

  xsup_xcount #(.CNT_W(CNT_W)) u_cnt (
    .xclk(xclk), .arst_n(x_rst_n), .req_t(req_t), .data(cdata),
    .ack_o(ack_x), .gray_o(gray_x)
  );

  xsup_sync_bits #(.WIDTH(1))     u_sstab (.clk(clk), .arst_n(s_rst_n), .d(stable_x), .q(stable_s));
  xsup_sync_bits #(.WIDTH(1))     u_sack  (.clk(clk), .arst_n(rst_n),   .d(ack_x),    .q(ack_s));
  xsup_sync_bits #(.WIDTH(CNT_W)) u_sgray (.clk(clk), .arst_n(rst_n),   .d(gray_x),   .q(gray_s));

  assign cnt_s  = gray_to_bin8(gray_s);
  assign osc_en = run;

  assert_stable_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en) |-> !bus_rdata[BIT_STABLE]);
endmodule

// File: tb/sim_xosc_supervisor.sv
module sim_xosc_supervisor;
  logic        clk = 0, rst_n = 0, xclk = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        osc_en;
  int          checks = 0, bad = 0;

  logic [11:0] m_en = 0, m_fr = 0;
  logic        m_bad = 0, m_nap = 0, m_x4 = 0;
  logic [13:0] m_dly = 14'hC4;

  xosc_supervisor u0 (.clk(clk), .rst_n(rst_n), .xclk(xclk), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .osc_en(osc_en));

  always #4 clk = ~clk;
  initial begin
    #1;
    forever begin
      #8;
      if (osc_en) xclk = ~xclk; else xclk = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[24] = m_bad;
    s[12] = (m_en == 12'hFAB);
    return s;
  endfunction

  always @(negedge clk) if (rst_n)
    chk(osc_en === ((m_en == 12'hFAB) && !m_nap), "R2 osc_en model", {31'b0, osc_en},
        {31'b0, (m_en == 12'hFAB) && !m_nap});

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 0; bus_we = 0;
    case (a)
      3'd0: begin
        if (d[23:12] == 12'hFAB || d[23:12] == 12'hD1E) m_en = d[23:12]; else m_bad = 1;
        if (d[11:0] == 12'hAA0) m_fr = d[11:0]; else m_bad = 1;
      end
      3'd1: if (d[24]) m_bad = 0;
      3'd2: if (d == 32'h636F6D61) m_nap = 1; else if (d == 32'h77616B65) m_nap = 0; else m_bad = 1;
      3'd3: begin m_dly = d[13:0]; m_x4 = d[20]; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  task automatic chk_regs(input string req);
    logic [31:0] v;
    rd(3'd0, v); chk(v === {8'b0, m_en, m_fr}, {req, " ctrl"}, v, {8'b0, m_en, m_fr});
    rd(3'd1, v); chk((v & 32'h7FFF_FFFF) === m_status(), {req, " status"}, v, m_status());
    rd(3'd2, v); chk(v === (m_nap ? 32'h636F6D61 : 32'h77616B65), {req, " pause"}, v,
                     m_nap ? 32'h636F6D61 : 32'h77616B65);
    rd(3'd3, v); chk(v === {11'b0, m_x4, 6'b0, m_dly}, {req, " startup"}, v, {11'b0, m_x4, 6'b0, m_dly});
  endtask

  task automatic chk_stable(input bit exp, input string req);
    logic [31:0] v;
    rd(3'd1, v);
    chk(v[31] === exp, req, {31'b0, v[31]}, {31'b0, exp});
  endtask

  task automatic bracket(input int lo, input int hi, input string req);
    repeat (lo) @(posedge clk);
    chk_stable(0, {req, " before delay"});
    repeat (hi - lo) @(posedge clk);
    chk_stable(1, {req, " after delay"});
  endtask

  task automatic chk_cnt_range(input int lo, input int hi, input string req);
    logic [31:0] v;
    rd(3'd4, v);
    chk(v >= lo && v <= hi, req, v, lo);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_regs("R1");
    rd(3'd4, v); chk(v === 0, "R1 counter", v, 0);
    rd(3'd1, v); chk(v === 0, "R1 status all zero", v, 0);
    // R3 illegal on/off code, legal range taken
    wr(3'd0, {8'b0, 12'h123, 12'hAA0}); chk_regs("R3 bad on/off");
    // R4 write of zero leaves flag, write of one clears
    wr(3'd1, 32'h0); chk_regs("R4 zero write");
    wr(3'd1, 32'h0100_0000); chk_regs("R4 clear");
    // R3 legal off code, illegal range
    wr(3'd0, {8'b0, 12'hD1E, 12'h555}); chk_regs("R3 bad range");
    wr(3'd1, 32'h0100_0000);
    // short startup delay of one unit
    wr(3'd3, 32'h0000_0001); chk_regs("R6 startup write");
    // R2 switch on
    wr(3'd0, {8'b0, 12'hFAB, 12'hAA0});
    chk_regs("R2 on");
    rd(3'd1, v); chk(v[1:0] === 2'b00, "R9 range bits", v, 0);
    // R6 settling bracket
    bracket(480, 560, "R6");
    // R10 counter load, decrement and hold
    wr(3'd4, 32'h20);
    repeat (100) @(posedge clk);
    chk_cnt_range(0, 0, "R10 reached zero");
    repeat (40) @(posedge clk);
    chk_cnt_range(0, 0, "R10 holds zero");
    wr(3'd4, 32'hF0);
    repeat (20) @(posedge clk);
    chk_cnt_range(8'hE0, 8'hF0, "R10 loaded");
    repeat (300) @(posedge clk);
    chk_cnt_range(60, 100, "R10 decrement rate");
    repeat (300) @(posedge clk);
    chk_cnt_range(0, 0, "R10 final zero");
    // R11 second write while first in flight is ignored
    wr(3'd4, 32'hF0);
    wr(3'd4, 32'h05);
    repeat (40) @(posedge clk);
    chk_cnt_range(8'hD0, 8'hF0, "R11 in-flight write dropped");
    // R8 switch off clears stable at once, switch on restarts
    wr(3'd0, {8'b0, 12'hD1E, 12'hAA0});
    chk_stable(0, "R8 off clears stable");
    chk_regs("R2 off");
    wr(3'd0, {8'b0, 12'hFAB, 12'hAA0});
    bracket(480, 560, "R8 restart after on");
    // R5 illegal pause code
    wr(3'd2, 32'h0000_1234); chk_regs("R5 bad pause code");
    wr(3'd1, 32'h0100_0000);
    // R5 sleep and wake
    wr(3'd2, 32'h636F6D61);
    chk_regs("R5 sleep");
    chk_stable(0, "R8 sleep clears stable");
    repeat (30) @(posedge clk);
    wr(3'd2, 32'h77616B65);
    chk_regs("R5 wake");
    bracket(480, 560, "R8 restart after wake");
    // R7 times four
    wr(3'd0, {8'b0, 12'hD1E, 12'hAA0});
    wr(3'd3, 32'h0010_0001); chk_regs("R7 startup write");
    wr(3'd0, {8'b0, 12'hFAB, 12'hAA0});
    bracket(1990, 2100, "R7");
    finish_run();
  end
endmodule